// File: doc/BRIEF.md
# Debug Power and Reset Status Register Slice

This block is the part of a processor's memory-mapped debug register space that reports power and reset conditions of the core to an external debugger. It offers a read-only status word and a one-bit control register. The status word shows whether the core's non-debug logic is in reset right now and whether the core is powered up right now. It also holds two sticky flags: one records that the core was reset since the debugger last read the word, and one records that the core went through a power-down.

Reading the status word clears both sticky flags, so each read reports only what happened since the read before it. The clear is suppressed while the core is still held in reset. A flag-setting event in the same cycle as a clearing read wins, so no event is lost. The control bit drives a request line that asks the power controller to emulate power-down while keeping power applied. A build parameter removes that line, and the bit then reads as zero.

Top module: `dbg_pwr_status`

## Requirements
- R1: After debug reset, rdata is 0 and keep_power_req is 0. The sticky reset flag starts at 1 and the sticky power-down flag starts at 0, so the first status read returns bit 3 = 1 and bit 1 = 0.
- R2: A read (rd_en = 1) at byte address 0x314 returns the status word on rdata in the cycle after the strobe. The fields are: bit 0 = core_powered, bit 1 = sticky power-down flag, bit 2 = core_in_reset, bit 3 = sticky reset flag, and bits 31:4 = 0. rdata holds its value when no read is made.
- R3: The sticky reset flag (status bit 3) becomes 1 in any cycle where core_in_reset is 1. It stays 1 until it is cleared.
- R4: A status read made while core_in_reset is 0 returns the flag values from before the clear. It then clears status bit 3 and status bit 1 to 0, unless a set event happens in that same cycle.
- R5: A status read made while core_in_reset is 1 clears neither sticky flag.
- R6: The sticky power-down flag (status bit 1) becomes 1 in any cycle where pdn_event is 1.
- R7: A pdn_event in the same cycle as a clearing status read keeps bit 1 at 1. The read itself returns the value bit 1 had before that cycle.
- R8: A write (wr_en = 1) to address 0x314 has no effect: keep_power_req and the status contents are unchanged.
- R9: With KEEP_IMPL = 1, a write to address 0x310 stores wdata bit 0. The stored value drives keep_power_req from the next cycle and reads back as bit 0 of 0x310, with bits 31:1 = 0.
- R10: With KEEP_IMPL = 0, address 0x310 reads 0, writes to it are ignored, and keep_power_req stays 0.
- R11: A read of any address other than 0x310 and 0x314 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst | input | 1 | Synchronous active-high debug reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, valid the cycle after rd_en |
| core_in_reset | input | 1 | Non-debug logic of the core is held in reset |
| core_powered | input | 1 | Core is powered up |
| pdn_event | input | 1 | One-cycle pulse when the core powers down |
| keep_power_req | output | 1 | Request to emulate power-down without removing power |

## Verification
A sticky flag stuck at 0 or at 1 appears on rdata at the next status read. A read that fails to clear appears at the read after that. A clear that ignores the in-reset hold, or that overrides a same-cycle event, appears at the first read after the event. A wrong decode shows up either as a wrong value on keep_power_req in the cycle after the write, or as a nonzero word from an address that should read as zero. The bench follows every cycle with a model of both flags, so any error is caught at the first read that exposes it.

// File: rtl/dbgps_pkg.sv
package dbgps_pkg;
  parameter int unsigned CTRL_OFS   = 32'h310;
  parameter int unsigned STATUS_OFS = 32'h314;
  parameter int unsigned B_PWRUP    = 0;
  parameter int unsigned B_SPDN     = 1;
  parameter int unsigned B_INRST    = 2;
  parameter int unsigned B_SRST     = 3;
  parameter int unsigned STAT_USED  = 4;
endpackage

// File: rtl/dbgps_sticky.sv
module dbgps_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)                  q_o <= RST_VAL;
    else if (set_i)           q_o <= 1'b1;
    else if (clr_i && !hold_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/dbgps_ctrl.sv
module dbgps_ctrl #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  generate
    if (IMPL) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst)       q_o <= 1'b0;
        else if (we_i) q_o <= d_i;
      end
    end else begin : g_none
      assign q_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dbgps_rdmux.sv
module dbgps_rdmux #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              sel_stat_i,
  input  logic              sel_ctrl_i,
  input  logic [DATA_W-1:0] stat_i,
  input  logic              ctrl_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    if (sel_stat_i)      word = stat_i;
    else if (sel_ctrl_i) word[0] = ctrl_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= word;
  end
endmodule

// File: rtl/dbg_pwr_status.sv
module dbg_pwr_status #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter bit KEEP_IMPL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              core_in_reset,
  input  logic              core_powered,
  input  logic              pdn_event,
  output logic              keep_power_req
);
  import dbgps_pkg::*;

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

  logic sel_stat, sel_ctrl, stat_rd;
  logic sticky_rst_q, sticky_pd_q;
  logic [DATA_W-1:0] stat_word;

  assign sel_stat = (addr == A_STAT);
  assign sel_ctrl = (addr == A_CTRL);
  assign stat_rd  = rd_en && sel_stat;

  dbgps_sticky #(.RST_VAL(1'b1)) u_srst (
    .clk(clk), .rst(rst), .set_i(core_in_reset), .clr_i(stat_rd),
    .hold_i(core_in_reset), .q_o(sticky_rst_q));

  dbgps_sticky #(.RST_VAL(1'b0)) u_spdn (
    .clk(clk), .rst(rst), .set_i(pdn_event), .clr_i(stat_rd),
    .hold_i(core_in_reset), .q_o(sticky_pd_q));

  dbgps_ctrl #(.IMPL(KEEP_IMPL)) u_ctrl (
    .clk(clk), .rst(rst), .we_i(wr_en && sel_ctrl), .d_i(wdata[0]),
    .q_o(keep_power_req));

  always_comb begin
    stat_word          = '0;
    stat_word[B_PWRUP] = core_powered;
    stat_word[B_SPDN]  = sticky_pd_q;
    stat_word[B_INRST] = core_in_reset;
    stat_word[B_SRST]  = sticky_rst_q;
  end

  dbgps_rdmux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_i(rd_en), .sel_stat_i(sel_stat),
    .sel_ctrl_i(sel_ctrl), .stat_i(stat_word), .ctrl_i(keep_power_req),
    .rdata_o(rdata));
endmodule

// File: rtl/dbgps_chk.sv
module dbgps_chk #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter bit KEEP_IMPL = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              core_in_reset,
  input logic              pdn_event,
  input logic              sticky_rst_q,
  input logic              sticky_pd_q,
  input logic              keep_power_req,
  input logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(dbgps_pkg::STATUS_OFS);

  // R3
  srst_set_chk: assert property (@(posedge clk) disable iff (rst)
    core_in_reset |=> sticky_rst_q);
  // R6
  spdn_set_chk: assert property (@(posedge clk) disable iff (rst)
    pdn_event |=> sticky_pd_q);
  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STAT && !core_in_reset && !pdn_event) |=> (!sticky_pd_q && !sticky_rst_q));
  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STAT && core_in_reset && sticky_pd_q) |=> sticky_pd_q);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STAT) |=> (rdata[DATA_W-1:dbgps_pkg::STAT_USED] == '0));
  // R8
  stat_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_STAT) |=> $stable(keep_power_req));
  // R10
  no_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !KEEP_IMPL |-> !keep_power_req);
endmodule

bind dbg_pwr_status dbgps_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEEP_IMPL(KEEP_IMPL)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .core_in_reset(core_in_reset), .pdn_event(pdn_event),
  .sticky_rst_q(sticky_rst_q), .sticky_pd_q(sticky_pd_q),
  .keep_power_req(keep_power_req), .rdata(rdata));

// File: tb/sim_dbg_pwr_status.sv
module sim_dbg_pwr_status;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_ST = 12'h314;
  localparam logic [AW-1:0] A_CT = 12'h310;

  logic clk = 0, rst = 1;
  logic rd_en = 0, wr_en = 0, core_in_reset = 0, core_powered = 0, pdn_event = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata0, rdata1;
  logic keep0, keep1;

  int checks = 0, failures = 0;
  logic m_srst, m_spd, m_ctrl;
  logic [DW-1:0] m_rd0, m_rd1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_pwr_status #(.ADDR_W(AW), .DATA_W(DW), .KEEP_IMPL(1'b1)) u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata0), .core_in_reset(core_in_reset), .core_powered(core_powered),
    .pdn_event(pdn_event), .keep_power_req(keep0));

  dbg_pwr_status #(.ADDR_W(AW), .DATA_W(DW), .KEEP_IMPL(1'b0)) u1 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata1), .core_in_reset(core_in_reset), .core_powered(core_powered),
    .pdn_event(pdn_event), .keep_power_req(keep1));

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] read_val(input logic [AW-1:0] a, input logic ctl,
                                             input logic in_rst, input logic pw);
    if (a == A_ST) return {28'd0, m_srst, in_rst, m_spd, pw};
    if (a == A_CT) return {31'd0, ctl};
    return '0;
  endfunction

  // one bus cycle: drive at negedge, model at posedge, check at next negedge
  task automatic cyc(input logic rd, input logic wr, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input logic inr, input logic pw,
                     input logic ev, input string tag);
    logic clr;
    rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    core_in_reset = inr; core_powered = pw; pdn_event = ev;
    @(posedge clk);
    if (rd) begin
      m_rd0 = read_val(a, m_ctrl, inr, pw);
      m_rd1 = read_val(a, 1'b0, inr, pw);
    end
    clr = rd && (a == A_ST) && !inr;
    m_srst = inr ? 1'b1 : (clr ? 1'b0 : m_srst);
    m_spd  = ev  ? 1'b1 : (clr ? 1'b0 : m_spd);
    if (wr && a == A_CT) m_ctrl = wd[0];
    @(negedge clk);
    chk({tag, " rdata0"}, rdata0, m_rd0);
    chk({tag, " rdata1 R10"}, rdata1, m_rd1);
    chk({tag, " keep0 R9"}, {31'd0, keep0}, {31'd0, m_ctrl});
    chk({tag, " keep1 R10"}, {31'd0, keep1}, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    m_srst = 1; m_spd = 0; m_ctrl = 0; m_rd0 = '0; m_rd1 = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rdata", rdata0, '0);
    chk("R1 keep", {31'd0, keep0}, '0);
    // R1 R2 first read sees sticky reset = 1
    cyc(1, 0, A_ST, 0, 0, 1, 0, "R1 first read");
    // R4 flag cleared
    cyc(1, 0, A_ST, 0, 0, 1, 0, "R4 cleared");
    // R3 reset pulse then R5 read while still in reset
    cyc(0, 0, A_ST, 0, 1, 0, 0, "R3 pulse");
    cyc(0, 0, A_ST, 0, 0, 0, 1, "R6 event");
    cyc(1, 0, A_ST, 0, 1, 0, 0, "R5 read in reset");
    cyc(1, 0, A_ST, 0, 0, 1, 0, "R5 still set");
    cyc(1, 0, A_ST, 0, 0, 1, 0, "R4 clear after");
    // R7 event meets clearing read
    cyc(1, 0, A_ST, 0, 0, 1, 1, "R7 collide");
    cyc(1, 0, A_ST, 0, 0, 1, 0, "R7 kept");
    // R9 control write
    cyc(0, 1, A_CT, 32'hFFFF_FFFF, 0, 1, 0, "R9 write");
    cyc(1, 0, A_CT, 0, 0, 1, 0, "R9 readback");
    // R8 status write ignored
    cyc(0, 1, A_ST, 32'h0, 0, 1, 0, "R8 write");
    cyc(1, 0, A_ST, 0, 0, 1, 0, "R8 read");
    // R11 unmapped
    cyc(1, 0, 12'h000, 0, 0, 1, 0, "R11 unmapped");
    cyc(1, 0, 12'h318, 0, 0, 1, 0, "R11 unmapped hi");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      int unsigned s;
      s = $urandom % 4;
      a = (s == 0) ? A_CT : (s == 3) ? AW'($urandom) : A_ST;
      cyc(($urandom % 2) == 0, ($urandom % 4) == 0, a, $urandom,
          ($urandom % 8) == 0, ($urandom % 2) == 0, ($urandom % 6) == 0, "R2 R4 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule